// File: doc/BRIEF.md
# SDRAM Auto-Precharge Bank Tracker

This block watches the registered command stream of a four-bank SDR SDRAM and keeps a model of each bank's life cycle. It covers write bursts that close their bank automatically, including bursts that a READ or WRITE to a different bank cuts short. Each bank is reported as idle, open, recovering from a write, or precharging. The block also produces a strobe, with bank and column, for each write data word the memory takes. A second strobe marks read data on the bus, delayed by the CAS latency.

A controller or a protocol monitor places it beside the command bus. It learns from the state outputs when a bank can be opened again, and from the error flag when a command was sent to a bank that is still closing. The burst length is four, and columns wrap inside an aligned group of four. Write recovery, precharge time and CAS latency are parameters.

Top module: `sdram_ap_tracker`

## Requirements
- R1: After a clock edge with `rst_n` low, every bank reports idle (code 0), `wr_valid`, `rd_valid` and `cmd_err` are low.
- R2: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3. Each bank reports its state on bits [2b+1:2b] of `bank_state`: 0 idle, 1 open, 2 write recovery, 3 precharging. An ACTIVATE to an idle bank makes it report open from the edge that registers it. An ACTIVATE to an open bank and a READ or WRITE to an idle bank are ignored: no state change, no strobe, no error.
- R3: A WRITE accepted at edge 0 with column a sets `wr_valid` after edges 0 to 3. `wr_bank` is the bank, and `wr_col` is a with its two low bits replaced by (a+k) mod 4 after edge k.
- R4: For an uninterrupted WRITE with auto precharge registered at edge 0, the bank reports open through edge 3, write recovery after edges 4 to 3+T_WR, precharging for the next T_RP edges, then idle.
- R5: A READ or WRITE without auto precharge leaves its bank open after the burst.
- R6: A READ or WRITE accepted at edge i (1 to 3) for another open bank ends the running burst at once. Its last word is the one from edge i-1. If the cut burst was an auto-precharge write, its bank enters write recovery at edge i and then follows the R4 timing from there.
- R7: When the interrupting command is a WRITE, its first word is taken at edge i, so `wr_valid` stays high while `wr_bank` switches to the new bank.
- R8: A READ accepted at edge 0 sets `rd_valid` after edges CAS_LAT-1 to CAS_LAT+2, so the data can be sampled CAS_LAT edges after the command.
- R9: A READ with auto precharge sends its bank straight to precharging at the edge where its burst ends (edge 4, or the edge of an interrupt). The bank stays there for T_RP edges, then becomes idle.
- R10: Any non-NOP command to a bank in write recovery or precharge, or any command to the bank of a running auto-precharge burst, raises `cmd_err` for one cycle after its edge. That command is ignored: no state change and no strobe, and the running burst goes on.
- R11: An interrupting command that carries its own auto-precharge flag is tracked on its bank by the same rules, while the interrupted bank follows its own timeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 2 | Registered command code (R2) |
| cmd_bank | input | 2 | Bank addressed by the command |
| cmd_col | input | COL_W | Start column of a READ or WRITE |
| cmd_ap | input | 1 | Auto-precharge request on a READ or WRITE |
| bank_state | output | 2*NUM_BANKS | Two-bit state per bank |
| wr_valid | output | 1 | A write word was taken at the previous edge |
| wr_bank | output | 2 | Bank of that write word |
| wr_col | output | COL_W | Column of that write word |
| rd_valid | output | 1 | Read data is on the bus |
| cmd_err | output | 1 | The previous command hit a closing bank |

## Verification
The bench sweeps every ordered pair of distinct banks, with the interrupt at edges 1 to 5, a READ or a WRITE, with and without its own auto precharge. This covers the case where the interrupt lands exactly on the natural end of the burst, and the case one edge after it. A design that counted recovery from the natural end, and not from the interrupting command, would keep the cut bank in recovery too long. A design that kept taking the cut burst's data would show the wrong bank on the write strobe. A design that sent read-precharge banks through write recovery would return them to idle T_WR edges late. Directed cases hit a bank while it recovers, while it precharges, and while its own burst runs, where a loose design would drop the flag or let the command through.

// File: rtl/sdram_apt_pkg.sv
// Shared command and bank-state encodings for the auto-precharge tracker.
// Assumes a two-bit command bus already registered by the controller.
package sdram_apt_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_ACT   = 2'd1,
        CMD_READ  = 2'd2,
        CMD_WRITE = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        BS_IDLE   = 2'd0,
        BS_ACTIVE = 2'd1,
        BS_WREC   = 2'd2,
        BS_PRE    = 2'd3
    } bank_st_e;

endpackage

// File: rtl/apt_bank_fsm.sv
// Per-bank life-cycle tracker: idle -> open -> (write recovery) -> precharge -> idle.
// Assumes end events arrive only while the bank is open and T_WR, T_RP >= 1.
module apt_bank_fsm
    import sdram_apt_pkg::*;
#(
    parameter int T_WR = 2,
    parameter int T_RP = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     open_i,
    input  logic     end_wr_i,
    input  logic     end_rd_i,
    output bank_st_e state_o
);

    localparam int CNT_MAX = (T_WR > T_RP) ? T_WR : T_RP;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    bank_st_e           state_q;
    logic [CNT_W-1:0]   cnt_q;

    // Advance the bank state and its recovery/precharge down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                BS_IDLE: begin
                    if (open_i) state_q <= BS_ACTIVE;
                end
                BS_ACTIVE: begin
                    if (end_wr_i) begin
                        state_q <= BS_WREC;
                        cnt_q   <= CNT_W'(T_WR - 1);
                    end else if (end_rd_i) begin
                        state_q <= BS_PRE;
                        cnt_q   <= CNT_W'(T_RP - 1);
                    end
                end
                BS_WREC: begin
                    if (cnt_q == '0) begin
                        state_q <= BS_PRE;
                        cnt_q   <= CNT_W'(T_RP - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == '0) state_q <= BS_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    assign state_o = state_q;

    a_r4_wrec_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_ACTIVE && end_wr_i) |=> state_q == BS_WREC);

    a_r4_wrec_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_WREC) |=> (state_q == BS_WREC || state_q == BS_PRE));

    a_r9_pre_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_PRE) |=> (state_q == BS_PRE || state_q == BS_IDLE));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_IDLE && !open_i) |=> state_q == BS_IDLE);

    a_r6_end_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (end_wr_i || end_rd_i) |-> state_q == BS_ACTIVE);

endmodule

// File: rtl/apt_burst_engine.sv
// Single burst sequencer shared by all banks: issues one word per cycle,
// ends a burst naturally after BURST_LEN words or at once when a new burst starts.
// Assumes BURST_LEN is a power of two >= 2 and that starts are pre-qualified.
module apt_burst_engine #(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 start_wr_i,
    input  logic                 start_ap_i,
    input  logic [BANK_W-1:0]    start_bank_i,
    input  logic [COL_W-1:0]     start_col_i,
    output logic [NUM_BANKS-1:0] end_wr_ap_o,
    output logic [NUM_BANKS-1:0] end_rd_ap_o,
    output logic                 busy_ap_o,
    output logic [BANK_W-1:0]    busy_bank_o,
    output logic                 wr_valid_o,
    output logic [BANK_W-1:0]    wr_bank_o,
    output logic [COL_W-1:0]     wr_col_o,
    output logic                 rd_issue_o
);

    localparam int OFF_W = $clog2(BURST_LEN);
    localparam int IDX_W = OFF_W + 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BURST_LEN);

    logic               busy_q;
    logic               wr_q;
    logic               ap_q;
    logic [BANK_W-1:0]  bank_q;
    logic [COL_W-1:0]   base_q;
    logic [IDX_W-1:0]   idx_q;

    logic               running;
    logic               finish;
    logic               issue;
    logic               issue_wr;
    logic [BANK_W-1:0]  issue_bank;
    logic [COL_W-1:0]   issue_col;
    logic [OFF_W-1:0]   wrap_off;

    // Decide whether a word goes out this cycle and whether the held burst ends.
    always_comb begin
        running    = busy_q && (idx_q < IDX_LAST);
        finish     = busy_q && ((idx_q == IDX_LAST) ||
                                (start_i && start_bank_i != bank_q));
        issue      = start_i || running;
        issue_wr   = start_i ? start_wr_i   : wr_q;
        issue_bank = start_i ? start_bank_i : bank_q;
        wrap_off   = base_q[OFF_W-1:0] + idx_q[OFF_W-1:0];
        issue_col  = start_i ? start_col_i
                             : {base_q[COL_W-1:OFF_W], wrap_off};
    end

    // Tell the bank that owned an ending auto-precharge burst how to close.
    always_comb begin
        end_wr_ap_o = '0;
        end_rd_ap_o = '0;
        if (finish && ap_q) begin
            if (wr_q) end_wr_ap_o = NUM_BANKS'(1) << bank_q;
            else      end_rd_ap_o = NUM_BANKS'(1) << bank_q;
        end
    end

    // Hold the current burst: owner, kind, base column and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            ap_q   <= 1'b0;
            bank_q <= '0;
            base_q <= '0;
            idx_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            wr_q   <= start_wr_i;
            ap_q   <= start_ap_i;
            bank_q <= start_bank_i;
            base_q <= start_col_i;
            idx_q  <= IDX_W'(1);
        end else if (running) begin
            idx_q  <= idx_q + 1'b1;
        end else begin
            busy_q <= 1'b0;
        end
    end

    // Register the write-word strobe with its bank and column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_o <= 1'b0;
            wr_bank_o  <= '0;
            wr_col_o   <= '0;
        end else begin
            wr_valid_o <= issue && issue_wr;
            wr_bank_o  <= issue_bank;
            wr_col_o   <= issue_col;
        end
    end

    assign rd_issue_o  = issue && !issue_wr;
    assign busy_ap_o   = busy_q && ap_q;
    assign busy_bank_o = bank_q;

    a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> idx_q <= IDX_LAST);

    a_r3_word_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_q && !start_i) |=> (wr_valid_o && wr_bank_o == $past(bank_q)));

endmodule

// File: rtl/apt_rd_pipe.sv
// Delay line that turns read-word issue events into a data-valid strobe
// CAS_LAT edges later. Assumes CAS_LAT >= 1.
module apt_rd_pipe #(
    parameter int CAS_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    output logic valid_o
);

    generate
        if (CAS_LAT == 1) begin : g_direct
            logic stage_q;
            // Single stage: strobe follows the issuing edge.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= issue_i;
            end
            assign valid_o = stage_q;
        end else begin : g_shift
            logic [CAS_LAT-1:0] pipe_q;
            // Shift issue events along the latency line.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[CAS_LAT-2:0], issue_i};
            end
            assign valid_o = pipe_q[CAS_LAT-1];
        end
    endgenerate

endmodule

// File: rtl/sdram_ap_tracker.sv
// Top of the bank tracker: qualifies each registered command against bank
// state, drives the shared burst engine, one FSM per bank and the read delay line.
// Assumes NUM_BANKS is a power of two and commands are already registered.
module sdram_ap_tracker
    import sdram_apt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4,
    parameter int T_WR      = 2,
    parameter int T_RP      = 3,
    parameter int CAS_LAT   = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             cmd_code,
    input  logic [BANK_W-1:0]      cmd_bank,
    input  logic [COL_W-1:0]       cmd_col,
    input  logic                   cmd_ap,
    output logic [2*NUM_BANKS-1:0] bank_state,
    output logic                   wr_valid,
    output logic [BANK_W-1:0]      wr_bank,
    output logic [COL_W-1:0]       wr_col,
    output logic                   rd_valid,
    output logic                   cmd_err
);

    cmd_e                   cmd;
    bank_st_e               st_w [NUM_BANKS];
    bank_st_e               tgt_st;
    logic                   reserved;
    logic                   is_rw;
    logic                   blocked;
    logic                   accept_rw;
    logic [NUM_BANKS-1:0]   open_req;
    logic [NUM_BANKS-1:0]   end_wr_ap;
    logic [NUM_BANKS-1:0]   end_rd_ap;
    logic                   busy_ap;
    logic [BANK_W-1:0]      busy_bank;
    logic                   rd_issue;

    // Qualify the incoming command against the addressed bank.
    always_comb begin
        cmd       = cmd_e'(cmd_code);
        tgt_st    = st_w[cmd_bank];
        reserved  = busy_ap && (busy_bank == cmd_bank);
        is_rw     = (cmd == CMD_READ) || (cmd == CMD_WRITE);
        blocked   = (cmd != CMD_NOP) &&
                    (tgt_st == BS_WREC || tgt_st == BS_PRE || reserved);
        accept_rw = is_rw && (tgt_st == BS_ACTIVE) && !reserved;
    end

    // Register the one-cycle error flag for a rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_err <= 1'b0;
        else        cmd_err <= blocked;
    end

    apt_burst_engine #(
        .NUM_BANKS (NUM_BANKS),
        .COL_W     (COL_W),
        .BURST_LEN (BURST_LEN)
    ) i_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept_rw),
        .start_wr_i   (cmd == CMD_WRITE),
        .start_ap_i   (cmd_ap),
        .start_bank_i (cmd_bank),
        .start_col_i  (cmd_col),
        .end_wr_ap_o  (end_wr_ap),
        .end_rd_ap_o  (end_rd_ap),
        .busy_ap_o    (busy_ap),
        .busy_bank_o  (busy_bank),
        .wr_valid_o   (wr_valid),
        .wr_bank_o    (wr_bank),
        .wr_col_o     (wr_col),
        .rd_issue_o   (rd_issue)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign open_req[b] = (cmd == CMD_ACT) && (cmd_bank == BANK_W'(b)) &&
                                 (st_w[b] == BS_IDLE);

            apt_bank_fsm #(
                .T_WR (T_WR),
                .T_RP (T_RP)
            ) i_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .open_i   (open_req[b]),
                .end_wr_i (end_wr_ap[b]),
                .end_rd_i (end_rd_ap[b]),
                .state_o  (st_w[b])
            );

            assign bank_state[2*b +: 2] = st_w[b];
        end
    endgenerate

    apt_rd_pipe #(
        .CAS_LAT (CAS_LAT)
    ) i_rd_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (rd_issue),
        .valid_o (rd_valid)
    );

    a_r10_err_on_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP && tgt_st == BS_PRE) |=> cmd_err);

    a_r7_write_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_rw && cmd == CMD_WRITE) |=> (wr_valid && wr_bank == $past(cmd_bank)));

    a_r2_idle_rw_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && tgt_st == BS_IDLE) |=> !cmd_err);

    a_r10_blocked_no_open: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> open_req == '0);

endmodule

// File: tb/test_sdram_ap_tracker.sv
module test_sdram_ap_tracker;

    localparam int TWR = 2;
    localparam int TRP = 3;
    localparam int CL  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd_code = 2'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic [7:0] cmd_col = 8'd0;
    logic       cmd_ap = 1'b0;
    logic [7:0] bank_state;
    logic       wr_valid;
    logic [1:0] wr_bank;
    logic [7:0] wr_col;
    logic       rd_valid;
    logic       cmd_err;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sdram_ap_tracker #(
        .NUM_BANKS (4),
        .COL_W     (8),
        .BURST_LEN (4),
        .T_WR      (TWR),
        .T_RP      (TRP),
        .CAS_LAT   (CL)
    ) i_sdram_ap_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_code   (cmd_code),
        .cmd_bank   (cmd_bank),
        .cmd_col    (cmd_col),
        .cmd_ap     (cmd_ap),
        .bank_state (bank_state),
        .wr_valid   (wr_valid),
        .wr_bank    (wr_bank),
        .wr_col     (wr_col),
        .rd_valid   (rd_valid),
        .cmd_err    (cmd_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int st(input int b);
        return int'(bank_state[2*b +: 2]);
    endfunction

    function automatic int wcol(input int a, input int k);
        return (a & ~3) | ((a + k) & 3);
    endfunction

    // Drive one command for the next edge, then wait until after it.
    task automatic step(input int c, input int b, input int col, input int ap);
        cmd_code = 2'(c);
        cmd_bank = 2'(b);
        cmd_col  = 8'(col);
        cmd_ap   = 1'(ap);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    // Expected state of an auto-precharge write bank ending at edge e.
    function automatic int exp_wr_ap(input int k, input int e);
        if (k < e) return 1;
        if (k < e + TWR) return 2;
        if (k < e + TWR + TRP) return 3;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got 0 expected 1 (run did not end)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state
        for (int b = 0; b < 4; b++) chk("R1", "bank state", st(b), 0);
        chk("R1", "wr_valid", int'(wr_valid), 0);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "cmd_err", int'(cmd_err), 0);

        // R2: READ to idle bank 2 ignored, WRITE to idle bank 1 ignored
        step(2, 2, 0, 0);
        for (int k = 0; k < CL + 4; k++) begin
            chk("R2", "idle read state", st(2), 0);
            chk("R2", "idle read rd_valid", int'(rd_valid), 0);
            chk("R2", "idle read err", int'(cmd_err), 0);
            step(0, 0, 0, 0);
        end
        step(3, 1, 4, 1);
        chk("R2", "idle write wr_valid", int'(wr_valid), 0);
        chk("R2", "idle write state", st(1), 0);
        step(1, 2, 0, 0);
        chk("R2", "activate", st(2), 1);
        step(1, 2, 0, 0);
        chk("R2", "re-activate state", st(2), 1);
        chk("R2", "re-activate err", int'(cmd_err), 0);

        // R10: commands to a closing bank are flagged and ignored
        do_reset();
        step(1, 0, 0, 0);
        for (int k = 0; k < 12; k++) begin
            int c, col, eerr, es, ev;
            c = 0; col = 0;
            if (k == 0) begin c = 3; col = 5; end
            if (k == 1) c = 2;
            if (k == 5) c = 3;
            if (k == 7) c = 1;
            if (k == 10) c = 1;
            step(c, 0, col, (k == 0) ? 1 : 0);
            eerr = (k == 1 || k == 5 || k == 7) ? 1 : 0;
            es = (k >= 10) ? 1 : exp_wr_ap(k, 4);
            ev = (k < 4) ? 1 : 0;
            chk("R10", "err flag", int'(cmd_err), eerr);
            chk("R10", "bank state", st(0), es);
            chk("R10", "wr_valid", int'(wr_valid), ev);
            if (ev == 1) chk("R10", "wr_col", int'(wr_col), wcol(5, k));
            chk("R10", "rd_valid", int'(rd_valid), 0);
        end

        // R3-R9, R11: sweep of interrupted and natural bursts
        for (int n = 0; n < 4; n++) begin
            for (int m = 0; m < 4; m++) begin
                if (m == n) continue;
                for (int i = 1; i <= 5; i++) begin
                    for (int mt = 0; mt < 2; mt++) begin
                        for (int map = 0; map < 2; map++) begin
                            int a, bc, e;
                            a  = n * 16 + 3 + i;
                            bc = m * 16 + 2 + mt;
                            e  = (i < 4) ? i : 4;
                            do_reset();
                            step(1, n, 0, 0);
                            step(1, m, 0, 0);
                            step(0, 0, 0, 0);
                            for (int k = 0; k < 20; k++) begin
                                int en, em, ev, eb, ec, er;
                                if (k == 0)      step(3, n, a, 1);
                                else if (k == i) step(mt ? 2 : 3, m, bc, map);
                                else             step(0, 0, 0, 0);
                                en = exp_wr_ap(k, e);
                                if (k < i + 4 || map == 0) em = 1;
                                else if (mt == 0) em = exp_wr_ap(k, i + 4);
                                else em = (k < i + 4 + TRP) ? 3 : 0;
                                ev = 0; eb = 0; ec = 0;
                                if (k < e) begin ev = 1; eb = n; ec = wcol(a, k); end
                                else if (mt == 0 && k >= i && k < i + 4) begin
                                    ev = 1; eb = m; ec = wcol(bc, k - i);
                                end
                                er = (mt == 1 && k >= i + CL - 1 && k <= i + CL + 2) ? 1 : 0;
                                chk((i < 4) ? "R6" : "R4", "interrupted bank state", st(n), en);
                                chk(map ? "R11" : "R5", mt ? "R9 second bank state" : "second bank state", st(m), em);
                                chk((k < e) ? "R3" : "R7", "wr_valid", int'(wr_valid), ev);
                                if (ev == 1) begin
                                    chk("R7", "wr_bank", int'(wr_bank), eb);
                                    chk("R3", "wr_col", int'(wr_col), ec);
                                end
                                chk("R8", "rd_valid", int'(rd_valid), er);
                                chk("R10", "no error", int'(cmd_err), 0);
                            end
                        end
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule